// File: doc/BRIEF.md
# CAN Standard-Frame Receiver with Acceptance Filtering

This block sits behind a bit-timing and de-stuffing stage. It takes one already sampled, stuff-free bus bit on each cycle that its strobe is high and walks the fields of a CAN data or remote frame. It captures the 11-bit identifier, the remote-request flag, the length code and up to eight payload bytes. A separate CRC unit reports whether the checksum matched. In the ACK slot the block asks the bus driver to pull the line dominant for every frame that arrived intact.

After the end-of-frame bits have all been seen recessive, the identifier and remote flag are tested against a set of programmable compare/mask filters, two by default. A standard frame that passes at least one filter is handed on with a one-cycle pulse and a per-filter hit vector. The bench models the bus as a wired-AND, so the block's own ACK reads back dominant. Extended-format frames are followed to their end so that the block stays in step with the bus, and they are acknowledged, but their contents are never delivered.

Top module: `can_std_rx`

## Requirements
- R1: After reset `ack_drive` and `frame_valid` are low, every captured output and `rx_match` is zero, and the block waits for a dominant start bit.
- R2: Field order is: dominant start bit, 11 identifier bits MSB first, RTR, IDE, r0, 4 DLC bits MSB first, data bytes each MSB first, 15 CRC bits, CRC delimiter. Byte k lands in `rx_data[8k+7:8k]`. Bytes beyond the received count read as zero.
- R3: A DLC above 8 consumes exactly 8 data bytes. A frame with RTR=1 carries no data bytes. `rx_dlc` reports the code exactly as received.
- R4: `ack_drive` is high for the whole ACK slot bit, from the strobe after the CRC delimiter up to the ACK slot strobe. It is high only if the CRC delimiter was recessive and `crc_ok` was high at the delimiter strobe. The filter outcome has no effect on it.
- R5: `frame_valid` is a single-cycle pulse on the second clock after the strobe of the last end-of-frame bit. The captured outputs change only together with that pulse.
- R6: Filter f hits when `(({id,rtr} ^ code_f) & ~mask_f) == 0`, with the RTR bit in bit 0 and mask bit 1 meaning don't care. Its hit is reported on `rx_match[f]`. A frame that hits no filter is still acknowledged, gives no pulse and leaves the outputs unchanged.
- R7: A frame with IDE=1 is parsed as 18 extension bits, then RTR, r1, r0, DLC, data and CRC. It is acknowledged and never delivered.
- R8: A dominant bit in the ACK delimiter or in any of the 7 end-of-frame bits aborts the frame with no pulse.
- R9: After the end of a frame or an abort, 3 consecutive recessive bits are required before a start bit is accepted. A dominant bit before that restarts the count and is not a start bit.
- R10: With `crc_ok` low at the CRC delimiter there is no acknowledge and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Strobe: `rx_bit` holds a new bus bit |
| rx_bit | input | 1 | De-stuffed bus bit, 0 = dominant |
| crc_ok | input | 1 | External CRC match, sampled at the CRC delimiter |
| flt_code | input | NUM_FILT*12 | Filter compare values, filter f in bits [12f+11:12f] |
| flt_mask | input | NUM_FILT*12 | Filter don't-care masks, same layout |
| ack_drive | output | 1 | Request to drive the ACK slot dominant |
| frame_valid | output | 1 | One-cycle pulse for an accepted standard frame |
| rx_id | output | 11 | Captured identifier |
| rx_rtr | output | 1 | Captured remote-request flag |
| rx_dlc | output | 4 | Captured length code |
| rx_data | output | 64 | Captured data bytes |
| rx_match | output | NUM_FILT | Per-filter hit vector of the delivered frame |

## Verification
The bench builds the block with its default parameters: two filters, seven end-of-frame bits and a three-bit intermission. With two filters it can show a frame accepted by each filter alone, one rejected by both, and the RTR bit taking part in the compare. The short intermission lets the bench place a dominant glitch inside the gap and show that the gap count restarts. Because every strobe is compared against a bit-level model, a miscounted field shows up as a misplaced ACK cycle or a missing pulse, and that includes the extension bits of extended frames.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

    localparam int ID_W      = 11;
    localparam int FILT_W    = ID_W + 1;
    localparam int DLC_W     = 4;
    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = MAX_BYTES * 8;
    localparam int CRC_W     = 15;
    localparam int EXT_W     = 18;
    localparam int CNT_W     = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_RTR,
        ST_IDE,
        ST_R0,
        ST_EXT,
        ST_DLC,
        ST_DATA,
        ST_CRC,
        ST_CRCDEL,
        ST_ACKSLOT,
        ST_ACKDEL,
        ST_EOF,
        ST_GAP
    } rx_state_e;

    typedef struct packed {
        rx_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [ID_W-1:0]    id;
        logic               rtr;
        logic               ide;
        logic [DLC_W-1:0]   dlc;
        logic [3:0]         nbytes;
        logic [DATA_W-1:0]  data;
        logic               ack_ok;
        logic               done;
    } parse_s;

endpackage

// File: rtl/can_rx_filter.sv
module can_rx_filter
    import can_rx_pkg::*;
(
    input  logic [FILT_W-1:0] key,
    input  logic [FILT_W-1:0] code,
    input  logic [FILT_W-1:0] mask,
    output logic              hit
);
    // R6: a mask bit of 1 removes that bit from the compare
    always_comb begin
        hit = (((key ^ code) & ~mask) == '0);
    end
endmodule

// File: rtl/can_rx_parse.sv
module can_rx_parse
    import can_rx_pkg::*;
#(
    parameter int EOF_BITS = 7,
    parameter int GAP_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              crc_ok,
    output logic              ack_drive,
    output logic              done,
    output logic [ID_W-1:0]   id,
    output logic              rtr,
    output logic [DLC_W-1:0]  dlc,
    output logic [DATA_W-1:0] data
);
    localparam logic [CNT_W-1:0] ID_LAST  = CNT_W'(ID_W - 1);
    localparam logic [CNT_W-1:0] DLC_LAST = CNT_W'(DLC_W - 1);
    localparam logic [CNT_W-1:0] CRC_LAST = CNT_W'(CRC_W - 1);
    localparam logic [CNT_W-1:0] EXT_RTR  = CNT_W'(EXT_W);
    localparam logic [CNT_W-1:0] EXT_LAST = CNT_W'(EXT_W + 2);
    localparam logic [CNT_W-1:0] EOF_LAST = CNT_W'(EOF_BITS - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_BITS - 1);

    parse_s q, d;

    logic [DLC_W-1:0] dlc_nxt;
    logic [3:0]       nb_nxt;
    logic [CNT_W-1:0] data_last;
    logic [5:0]       bit_idx;

    always_comb begin
        dlc_nxt   = {q.dlc[DLC_W-2:0], rx_bit};
        // R3: remote frames carry nothing, codes above 8 clamp to 8
        if (q.rtr)
            nb_nxt = 4'd0;
        else if (dlc_nxt > 4'd8)
            nb_nxt = 4'd8;
        else
            nb_nxt = dlc_nxt;
        data_last = {q.nbytes, 3'b000} - CNT_W'(1);
        // R2: byte index from upper count bits, MSB of each byte first
        bit_idx   = {q.cnt[5:3], ~q.cnt[2:0]};
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (bit_en) begin
            unique case (q.st)
                ST_IDLE: begin
                    if (!rx_bit) begin
                        d.st     = ST_ID;
                        d.cnt    = '0;
                        d.id     = '0;
                        d.rtr    = 1'b0;
                        d.ide    = 1'b0;
                        d.dlc    = '0;
                        d.nbytes = '0;
                        d.data   = '0;
                        d.ack_ok = 1'b0;
                    end
                end
                ST_ID: begin
                    d.id = {q.id[ID_W-2:0], rx_bit};
                    if (q.cnt == ID_LAST) begin
                        d.st  = ST_RTR;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_RTR: begin
                    d.rtr = rx_bit;
                    d.st  = ST_IDE;
                end
                ST_IDE: begin
                    d.ide = rx_bit;
                    d.cnt = '0;
                    d.st  = rx_bit ? ST_EXT : ST_R0;
                end
                ST_R0: begin
                    d.st  = ST_DLC;
                    d.cnt = '0;
                end
                ST_EXT: begin
                    // R7: extension bits, then the true RTR, then r1, r0
                    if (q.cnt == EXT_RTR)
                        d.rtr = rx_bit;
                    if (q.cnt == EXT_LAST) begin
                        d.st  = ST_DLC;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_DLC: begin
                    d.dlc = dlc_nxt;
                    if (q.cnt == DLC_LAST) begin
                        d.nbytes = nb_nxt;
                        d.cnt    = '0;
                        d.st     = (nb_nxt == 4'd0) ? ST_CRC : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (!q.ide)
                        d.data[bit_idx] = rx_bit;
                    if (q.cnt == data_last) begin
                        d.st  = ST_CRC;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_CRC: begin
                    if (q.cnt == CRC_LAST) begin
                        d.st  = ST_CRCDEL;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_CRCDEL: begin
                    // R4, R10: acknowledge only an intact frame
                    if (!rx_bit) begin
                        d.st     = ST_GAP;
                        d.cnt    = '0;
                        d.ack_ok = 1'b0;
                    end else begin
                        d.ack_ok = crc_ok;
                        d.st     = ST_ACKSLOT;
                    end
                end
                ST_ACKSLOT: begin
                    d.st = ST_ACKDEL;
                end
                ST_ACKDEL: begin
                    // R8
                    d.cnt = '0;
                    if (!rx_bit) begin
                        d.st     = ST_GAP;
                        d.ack_ok = 1'b0;
                    end else begin
                        d.st = ST_EOF;
                    end
                end
                ST_EOF: begin
                    if (!rx_bit) begin
                        // R8: dominant inside end of frame aborts
                        d.st     = ST_GAP;
                        d.cnt    = '0;
                        d.ack_ok = 1'b0;
                    end else if (q.cnt == EOF_LAST) begin
                        // R5, R7: only intact standard frames finish
                        d.done = q.ack_ok && !q.ide;
                        d.st   = ST_GAP;
                        d.cnt  = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_GAP: begin
                    // R9: consecutive recessive bits re-arm the receiver
                    if (!rx_bit) begin
                        d.cnt = '0;
                    end else if (q.cnt == GAP_LAST) begin
                        d.st  = ST_IDLE;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                default: begin
                    d.st  = ST_IDLE;
                    d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign ack_drive = (q.st == ST_ACKSLOT) && q.ack_ok;
    assign done      = q.done;
    assign id        = q.id;
    assign rtr       = q.rtr;
    assign dlc       = q.dlc;
    assign data      = q.data;

endmodule

// File: rtl/can_std_rx.sv
module can_std_rx
    import can_rx_pkg::*;
#(
    parameter int NUM_FILT = 2,
    parameter int EOF_BITS = 7,
    parameter int GAP_BITS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_en,
    input  logic                       rx_bit,
    input  logic                       crc_ok,
    input  logic [NUM_FILT*FILT_W-1:0] flt_code,
    input  logic [NUM_FILT*FILT_W-1:0] flt_mask,
    output logic                       ack_drive,
    output logic                       frame_valid,
    output logic [ID_W-1:0]            rx_id,
    output logic                       rx_rtr,
    output logic [DLC_W-1:0]           rx_dlc,
    output logic [DATA_W-1:0]          rx_data,
    output logic [NUM_FILT-1:0]        rx_match
);
    typedef struct packed {
        logic                valid;
        logic [ID_W-1:0]     id;
        logic                rtr;
        logic [DLC_W-1:0]    dlc;
        logic [DATA_W-1:0]   data;
        logic [NUM_FILT-1:0] match;
    } out_s;

    logic              p_done;
    logic [ID_W-1:0]   p_id;
    logic              p_rtr;
    logic [DLC_W-1:0]  p_dlc;
    logic [DATA_W-1:0] p_data;
    logic [NUM_FILT-1:0] hit;
    logic [FILT_W-1:0]   key;

    out_s o_q, o_d;

    can_rx_parse #(
        .EOF_BITS (EOF_BITS),
        .GAP_BITS (GAP_BITS)
    ) u_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .rx_bit    (rx_bit),
        .crc_ok    (crc_ok),
        .ack_drive (ack_drive),
        .done      (p_done),
        .id        (p_id),
        .rtr       (p_rtr),
        .dlc       (p_dlc),
        .data      (p_data)
    );

    assign key = {p_id, p_rtr};

    for (genvar f = 0; f < NUM_FILT; f++) begin : g_flt
        can_rx_filter u_flt (
            .key  (key),
            .code (flt_code[f*FILT_W +: FILT_W]),
            .mask (flt_mask[f*FILT_W +: FILT_W]),
            .hit  (hit[f])
        );
    end

    // R5, R6: outputs move only for an accepted finished frame
    always_comb begin
        o_d       = o_q;
        o_d.valid = 1'b0;
        if (p_done && (|hit)) begin
            o_d.valid = 1'b1;
            o_d.id    = p_id;
            o_d.rtr   = p_rtr;
            o_d.dlc   = p_dlc;
            o_d.data  = p_data;
            o_d.match = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign frame_valid = o_q.valid;
    assign rx_id       = o_q.id;
    assign rx_rtr      = o_q.rtr;
    assign rx_dlc      = o_q.dlc;
    assign rx_data     = o_q.data;
    assign rx_match    = o_q.match;

endmodule

// File: rtl/can_std_rx_chk.sv
module can_std_rx_chk
    import can_rx_pkg::*;
#(
    parameter int NUM_FILT = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bit_en,
    input logic                ack_drive,
    input logic                frame_valid,
    input logic [ID_W-1:0]     rx_id,
    input logic [DATA_W-1:0]   rx_data,
    input logic [NUM_FILT-1:0] rx_match
);
    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R4
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ack_drive));

    // R6
    valid_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (rx_match != '0));

    // R5
    id_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_id) |-> frame_valid);

    // R5
    data_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> frame_valid);

    // R4
    ack_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive |-> !frame_valid);
endmodule

bind can_std_rx can_std_rx_chk #(.NUM_FILT(NUM_FILT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .ack_drive   (ack_drive),
    .frame_valid (frame_valid),
    .rx_id       (rx_id),
    .rx_data     (rx_data),
    .rx_match    (rx_match)
);

// File: tb/sim_can_std_rx.sv
module sim_can_std_rx;
    localparam int NF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic tx_bit = 1'b1;
    logic crc_ok = 1'b1;
    logic rx_bit;
    logic [NF*12-1:0] flt_code;
    logic [NF*12-1:0] flt_mask;
    logic        ack_drive, frame_valid, rx_rtr;
    logic [10:0] rx_id;
    logic [3:0]  rx_dlc;
    logic [63:0] rx_data;
    logic [NF-1:0] rx_match;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // wired-AND bus: our own ACK reads back dominant
    assign rx_bit = tx_bit & ~ack_drive;

    always #5 clk = ~clk;

    can_std_rx u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .crc_ok(crc_ok), .flt_code(flt_code), .flt_mask(flt_mask),
        .ack_drive(ack_drive), .frame_valid(frame_valid), .rx_id(rx_id),
        .rx_rtr(rx_rtr), .rx_dlc(rx_dlc), .rx_data(rx_data), .rx_match(rx_match)
    );

    // model state
    bit fq[$];
    int ack_idx;
    int last_eof_idx;
    logic [10:0] m_id  = '0;
    logic        m_rtr = 1'b0;
    logic [3:0]  m_dlc = '0;
    logic [63:0] m_data = '0;
    logic [NF-1:0] m_match = '0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [NF-1:0] model_hits(input logic [10:0] id, input logic rtr);
        logic [NF-1:0] h;
        for (int f = 0; f < NF; f++) begin
            logic [11:0] k, c, m;
            k = {id, rtr};
            c = flt_code[f*12 +: 12];
            m = flt_mask[f*12 +: 12];
            h[f] = (((k ^ c) & ~m) == 12'd0);
        end
        return h;
    endfunction

    function automatic int nbytes(input logic rtr, input logic [3:0] dlc);
        if (rtr) return 0;
        if (dlc > 4'd8) return 8;
        return int'(dlc);
    endfunction

    task automatic build(input logic [10:0] id, input logic rtr, input logic ide,
                         input logic [17:0] ext, input logic [3:0] dlc,
                         input logic [63:0] data);
        int nb;
        fq.delete();
        fq.push_back(1'b0);
        for (int i = 10; i >= 0; i--) fq.push_back(id[i]);
        if (!ide) begin
            fq.push_back(rtr); fq.push_back(1'b0); fq.push_back(1'b0);
        end else begin
            fq.push_back(1'b1); fq.push_back(1'b1);
            for (int i = 17; i >= 0; i--) fq.push_back(ext[i]);
            fq.push_back(rtr); fq.push_back(1'b0); fq.push_back(1'b0);
        end
        for (int i = 3; i >= 0; i--) fq.push_back(dlc[i]);
        nb = nbytes(rtr, dlc);
        for (int k = 0; k < nb; k++)
            for (int b = 7; b >= 0; b--) fq.push_back(data[8*k + b]);
        for (int j = 0; j < 15; j++) fq.push_back((j % 3) == 1);
        fq.push_back(1'b1);
        ack_idx = fq.size();
        fq.push_back(1'b1);
        fq.push_back(1'b1);
        for (int j = 0; j < 7; j++) fq.push_back(1'b1);
        last_eof_idx = fq.size() - 1;
        for (int j = 0; j < 3; j++) fq.push_back(1'b1);
    endtask

    // sends fq; ack_exp says the slot must be driven, deliver says a pulse is due
    task automatic send(input string req, input bit crc, input bit ack_exp,
                        input bit deliver);
        for (int i = 0; i < fq.size(); i++) begin
            @(negedge clk);
            tx_bit = fq[i];
            crc_ok = crc;
            bit_en = 1'b1;
            chk(req, "ack_drive", 64'(ack_drive), 64'(ack_exp && i == ack_idx));
            chk(req, "frame_valid", 64'(frame_valid), 64'd0);
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                bit_en = 1'b0;
                chk(req, "ack_drive", 64'(ack_drive), 64'(ack_exp && (i + 1) == ack_idx));
                chk(req, "frame_valid", 64'(frame_valid),
                    64'(deliver && j == 1 && i == last_eof_idx));
            end
        end
        tx_bit = 1'b1;
        chk(req, "rx_id", 64'(rx_id), 64'(m_id));
        chk(req, "rx_rtr", 64'(rx_rtr), 64'(m_rtr));
        chk(req, "rx_dlc", 64'(rx_dlc), 64'(m_dlc));
        chk(req, "rx_data", rx_data, m_data);
        chk(req, "rx_match", 64'(rx_match), 64'(m_match));
    endtask

    task automatic frame(input string req, input logic [10:0] id, input logic rtr,
                         input logic ide, input logic [3:0] dlc, input logic [63:0] data,
                         input bit crc, input int corrupt);
        logic [NF-1:0] h;
        bit deliver;
        logic [63:0] kept;
        int nb;
        build(id, rtr, ide, 18'h2A5C3, dlc, data);
        if (corrupt >= 0) fq[corrupt] = 1'b0;
        h = model_hits(id, rtr);
        deliver = !ide && crc && (h != '0) && (corrupt < 0);
        nb = nbytes(rtr, dlc);
        kept = '0;
        for (int k = 0; k < nb; k++) kept[8*k +: 8] = data[8*k +: 8];
        if (deliver) begin
            m_id = id; m_rtr = rtr; m_dlc = dlc; m_data = kept; m_match = h;
        end
        send(req, crc, crc, deliver);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        flt_code = {12'h800, {11'h123, 1'b0}};
        flt_mask = {12'h0FF, 12'h000};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "ack_drive", 64'(ack_drive), 64'd0);
        chk("R1", "frame_valid", 64'(frame_valid), 64'd0);
        chk("R1", "rx_id", 64'(rx_id), 64'd0);
        chk("R1", "rx_data", rx_data, 64'd0);
        chk("R1", "rx_match", 64'(rx_match), 64'd0);

        // R2 R6: two bytes, exact match on filter 0; unused bytes zero
        frame("R2", 11'h123, 1'b0, 1'b0, 4'd2, 64'h1122_3344_5566_BEEF, 1'b1, -1);
        // R6: masked match on filter 1 only, full eight bytes
        frame("R6", 11'h45A, 1'b0, 1'b0, 4'd8, 64'h0807_0605_0403_0201, 1'b1, -1);
        // R6 R4: rejected by both, still acknowledged, outputs held
        frame("R6", 11'h2AA, 1'b0, 1'b0, 4'd1, 64'h55, 1'b1, -1);
        // R6: RTR bit takes part in the compare (filter 0 wants RTR=0)
        frame("R6", 11'h123, 1'b1, 1'b0, 4'd3, 64'h0, 1'b1, -1);
        // R3: remote frame with a non-zero code carries no data
        frame("R3", 11'h470, 1'b1, 1'b0, 4'd4, 64'hFFFF_FFFF, 1'b1, -1);
        // R3: code 15 consumes eight bytes
        frame("R3", 11'h123, 1'b0, 1'b0, 4'd15, 64'hA1B2_C3D4_E5F6_0718, 1'b1, -1);
        // R2: zero-length data frame
        frame("R2", 11'h123, 1'b0, 1'b0, 4'd0, 64'hDEAD, 1'b1, -1);
        // R7: extended frame acknowledged, never delivered
        frame("R7", 11'h123, 1'b0, 1'b1, 4'd5, 64'h99_8877_6655, 1'b1, -1);
        // R10: CRC mismatch
        frame("R10", 11'h123, 1'b0, 1'b0, 4'd1, 64'h42, 1'b0, -1);
        // R8: dominant in the fourth end-of-frame bit
        build(11'h123, 1'b0, 1'b0, 18'h0, 4'd1, 64'h0);
        frame("R8", 11'h123, 1'b0, 1'b0, 4'd1, 64'h77, 1'b1, last_eof_idx - 3);
        // R8: dominant ACK delimiter
        frame("R8", 11'h123, 1'b0, 1'b0, 4'd1, 64'h66, 1'b1, ack_idx + 1);
        // R9: dominant glitch inside the gap, then a good frame
        build(11'h123, 1'b0, 1'b0, 18'h0, 4'd1, 64'h3C);
        m_id = 11'h123; m_rtr = 1'b0; m_dlc = 4'd1; m_data = 64'h3C; m_match = 2'b01;
        void'(fq.pop_back());
        fq.push_back(1'b0);
        for (int j = 0; j < 3; j++) fq.push_back(1'b1);
        send("R9", 1'b1, 1'b1, 1'b1);
        frame("R9", 11'h4C1, 1'b0, 1'b0, 4'd3, 64'hCAFE01, 1'b1, -1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule